// File: doc/BRIEF.md
# Video Fetch Memory Front End

This block sits between a character-based video controller and its two memories. A single access slot yields a 12-bit fetch word. The low byte is a screen code read from dynamic RAM. The high nibble is a colour value read from a separate 1024 x 4 static colour RAM, and both halves are sampled on the same clock edge. The DRAM receives a multiplexed address: the row part is driven with RAS, then the column part with CAS. The colour RAM receives a plain 10-bit address that stays put for the whole access.

A static strap picks a page of 128 or 256 bytes. This decides which address bits travel in the row phase and which in the column phase, so pin 0 carries address bit 7 or bit 8 during the row phase and bit 0 during the column phase. The controller marks each slot as a video or a CPU slot. In a CPU slot the address comes from the CPU side and the data path is 8 bits wide. The CPU can then read or write the screen DRAM, or reach the colour RAM through its low four data bits.

Top module: `vfm_memif`

## Requirements
- R1: While reset is held and after it, all four active-low strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `col_we_n`) are high and both `fetch_valid` and `cpu_rvalid` are low.
- R2: An access starts when `acc_start` is high on a clock edge with the block idle. After that edge `dram_ras_n` is low, `dram_cas_n` is high and `dram_ma` holds the row: `dram_ma[i]` = address bit i+8 when `page_wide`=1, or address bit i+7 when `page_wide`=0. Pins past the top address bit read 0.
- R3: One cycle later `dram_cas_n` falls while `dram_ras_n` stays low, and `dram_ma` holds the column: address bits 7..0 when `page_wide`=1, or bits 6..0 with pin 7 at 0 when `page_wide`=0.
- R4: From the row cycle through the end of the access, `col_addr` equals address bits 9..0 and does not change.
- R5: In a video slot, `fetch_valid` pulses for exactly one cycle, the cycle after the CAS cycle, with both strobes still low. `fetch_word` = {colour nibble, DRAM byte} read at that address.
- R6: An access lasts four cycles. In its last cycle all strobes are high again. `acc_start` is ignored while an access is in progress, so a start held through a busy access begins no second access.
- R7: In a CPU slot (`acc_cpu`=1) the address is taken from `cpu_addr` and `vid_addr` is ignored. A DRAM read (`cpu_col`=0, `cpu_we`=0) returns the byte on `cpu_rdata` with a one-cycle `cpu_rvalid`, timed like R5.
- R8: A CPU colour read (`cpu_col`=1, `cpu_we`=0) returns {4'b0000, colour nibble} on `cpu_rdata` and writes neither memory.
- R9: A CPU colour write drives `col_we_n` low during the CAS and capture cycles, with `col_dout` = `cpu_wdata[3:0]`, and keeps `dram_we_n` high. Later video fetches of that address carry the nibble in `fetch_word[11:8]`.
- R10: A CPU DRAM write drives `dram_we_n` low during the CAS and capture cycles, with `dram_dout` = `cpu_wdata`, and keeps `col_we_n` high.
- R11: A video slot asserts neither write enable, and a CPU slot never raises `fetch_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| page_wide | input | 1 | Strap: 1 = 256-byte DRAM page, 0 = 128-byte page |
| acc_start | input | 1 | Begin an access slot (taken only when idle) |
| acc_cpu | input | 1 | Slot kind: 1 = CPU slot, 0 = video slot |
| vid_addr | input | 12 | Video fetch address |
| cpu_addr | input | 12 | CPU address |
| cpu_we | input | 1 | CPU slot writes |
| cpu_col | input | 1 | CPU slot targets colour RAM instead of DRAM |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| cpu_rvalid | output | 1 | One-cycle CPU read strobe |
| dram_ma | output | 8 | Multiplexed DRAM address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | DRAM write enable, active low |
| dram_dout | output | 8 | DRAM write data |
| dram_din | input | 8 | DRAM read data |
| col_addr | output | 10 | Colour RAM address, not multiplexed |
| col_we_n | output | 1 | Colour RAM write enable, active low |
| col_dout | output | 4 | Colour RAM write data |
| col_din | input | 4 | Colour RAM read data |
| fetch_word | output | 12 | Captured video word {colour, screen code} |
| fetch_valid | output | 1 | One-cycle fetch strobe |

## Verification
The bench uses addresses whose upper bits differ only at bits 7 and 8, and it runs them under both strap settings. A design that moved the row/column split the wrong way, or ignored the strap, would put a wrong byte on `dram_ma` and would also read the wrong cell of the modelled DRAM. A CPU colour write followed by a video fetch exposes a design that routes the nibble to the DRAM, uses the wrong half of the data bus, or lets `col_addr` move while it is in use. A start held across a busy access catches a sequencer that re-arms early, and a CPU slot with a decoy video address catches a wrong source select.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROW  = 2'd1,
      ST_COL  = 2'd2,
      ST_LAT  = 2'd3
   } acc_state_t;

   typedef struct packed {
      logic cpu;
      logic we;
      logic col;
   } acc_kind_t;

endpackage

// File: rtl/vfm_addr_split.sv
module vfm_addr_split #(
   parameter int ADDR_W     = 12,
   parameter int MA_W       = 8,
   parameter int WIDE_COL_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              page_wide,
   output logic [MA_W-1:0]   row_ma,
   output logic [MA_W-1:0]   col_ma
);

   localparam int NARROW_COL_W = WIDE_COL_W - 1;

   logic [MA_W-1:0] row_w, row_n, col_w, col_n;

   for (genvar i = 0; i < MA_W; i++) begin : g_pin
      if (i < WIDE_COL_W && i < ADDR_W) begin : g_cw
         assign col_w[i] = addr[i];
      end else begin : g_cw0
         assign col_w[i] = 1'b0;
      end

      if (i < NARROW_COL_W && i < ADDR_W) begin : g_cn
         assign col_n[i] = addr[i];
      end else begin : g_cn0
         assign col_n[i] = 1'b0;
      end

      if (i + WIDE_COL_W < ADDR_W) begin : g_rw
         assign row_w[i] = addr[i+WIDE_COL_W];
      end else begin : g_rw0
         assign row_w[i] = 1'b0;
      end

      if (i + NARROW_COL_W < ADDR_W) begin : g_rn
         assign row_n[i] = addr[i+NARROW_COL_W];
      end else begin : g_rn0
         assign row_n[i] = 1'b0;
      end
   end

   assign row_ma = page_wide ? row_w : row_n;
   assign col_ma = page_wide ? col_w : col_n;

endmodule

// File: rtl/vfm_seq.sv
module vfm_seq
   import vfm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_start,
   input  logic       acc_cpu,
   input  logic       cpu_we,
   input  logic       cpu_col,
   output acc_state_t state,
   output acc_kind_t  kind,
   output logic       load,
   output logic       ras_n,
   output logic       cas_n,
   output logic       dram_we_n,
   output logic       col_we_n
);

   assign load = (state == ST_IDLE) && acc_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= '0;
         ras_n     <= 1'b1;
         cas_n     <= 1'b1;
         dram_we_n <= 1'b1;
         col_we_n  <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (acc_start) begin
                  state    <= ST_ROW;
                  ras_n    <= 1'b0;
                  kind.cpu <= acc_cpu;
                  kind.we  <= acc_cpu & cpu_we;
                  kind.col <= acc_cpu & cpu_col;
               end
            end
            ST_ROW: begin
               state     <= ST_COL;
               cas_n     <= 1'b0;
               dram_we_n <= ~(kind.we & ~kind.col);
               col_we_n  <= ~(kind.we & kind.col);
            end
            ST_COL: begin
               state <= ST_LAT;
            end
            default: begin
               state     <= ST_IDLE;
               ras_n     <= 1'b1;
               cas_n     <= 1'b1;
               dram_we_n <= 1'b1;
               col_we_n  <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/vfm_datapath.sv
module vfm_datapath
   import vfm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int MA_W   = 8,
   parameter int COL_AW = 10,
   parameter int DW     = 8,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  acc_state_t        state,
   input  acc_kind_t         kind,
   input  logic              page_wide,
   input  logic              acc_cpu,
   input  logic [ADDR_W-1:0] vid_addr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic [DW-1:0]     dram_din,
   input  logic [CW-1:0]     col_din,
   output logic [MA_W-1:0]   dram_ma,
   output logic [DW-1:0]     dram_dout,
   output logic [COL_AW-1:0] col_addr,
   output logic [CW-1:0]     col_dout,
   output logic [DW+CW-1:0]  fetch_word,
   output logic              fetch_valid,
   output logic [DW-1:0]     cpu_rdata,
   output logic              cpu_rvalid
);

   localparam int PAD_W = DW - CW;

   logic [ADDR_W-1:0] sel_addr, lat_addr;
   logic [MA_W-1:0]   sel_row, sel_col_unused, lat_row_unused, lat_col;
   logic [DW-1:0]     wdata_q;

   assign sel_addr = acc_cpu ? cpu_addr : vid_addr;

   vfm_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) i_split_next (
      .addr      (sel_addr),
      .page_wide (page_wide),
      .row_ma    (sel_row),
      .col_ma    (sel_col_unused)
   );

   vfm_addr_split #(.ADDR_W(ADDR_W), .MA_W(MA_W)) i_split_held (
      .addr      (lat_addr),
      .page_wide (page_wide),
      .row_ma    (lat_row_unused),
      .col_ma    (lat_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr    <= '0;
         dram_ma     <= '0;
         col_addr    <= '0;
         wdata_q     <= '0;
         fetch_word  <= '0;
         fetch_valid <= 1'b0;
         cpu_rdata   <= '0;
         cpu_rvalid  <= 1'b0;
      end else begin
         fetch_valid <= 1'b0;
         cpu_rvalid  <= 1'b0;
         if (load) begin
            lat_addr <= sel_addr;
            dram_ma  <= sel_row;
            col_addr <= sel_addr[COL_AW-1:0];
            wdata_q  <= cpu_wdata;
         end
         if (state == ST_ROW) begin
            dram_ma <= lat_col;
         end
         if (state == ST_COL) begin
            if (!kind.cpu) begin
               fetch_word  <= {col_din, dram_din};
               fetch_valid <= 1'b1;
            end else if (!kind.we) begin
               cpu_rdata  <= kind.col ? {{PAD_W{1'b0}}, col_din} : dram_din;
               cpu_rvalid <= 1'b1;
            end
         end
      end
   end

   assign dram_dout = wdata_q;
   assign col_dout  = wdata_q[CW-1:0];

endmodule

// File: rtl/vfm_memif.sv
module vfm_memif
   import vfm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int MA_W   = 8,
   parameter int COL_AW = 10,
   parameter int DW     = 8,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_wide,
   input  logic              acc_start,
   input  logic              acc_cpu,
   input  logic [ADDR_W-1:0] vid_addr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_we,
   input  logic              cpu_col,
   input  logic [DW-1:0]     cpu_wdata,
   output logic [DW-1:0]     cpu_rdata,
   output logic              cpu_rvalid,
   output logic [MA_W-1:0]   dram_ma,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [DW-1:0]     dram_dout,
   input  logic [DW-1:0]     dram_din,
   output logic [COL_AW-1:0] col_addr,
   output logic              col_we_n,
   output logic [CW-1:0]     col_dout,
   input  logic [CW-1:0]     col_din,
   output logic [DW+CW-1:0]  fetch_word,
   output logic              fetch_valid
);

   if (MA_W < 8) begin : g_chk_ma
      $error("vfm_memif: MA_W must hold a full 256-byte column");
   end
   if (ADDR_W < COL_AW || ADDR_W > 2 * MA_W) begin : g_chk_aw
      $error("vfm_memif: ADDR_W out of range for the pin count");
   end
   if (CW > DW) begin : g_chk_cw
      $error("vfm_memif: colour width exceeds CPU data width");
   end

   acc_state_t state;
   acc_kind_t  kind;
   logic       load;

   vfm_seq i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_start (acc_start),
      .acc_cpu   (acc_cpu),
      .cpu_we    (cpu_we),
      .cpu_col   (cpu_col),
      .state     (state),
      .kind      (kind),
      .load      (load),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .dram_we_n (dram_we_n),
      .col_we_n  (col_we_n)
   );

   vfm_datapath #(
      .ADDR_W(ADDR_W), .MA_W(MA_W), .COL_AW(COL_AW), .DW(DW), .CW(CW)
   ) i_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .state       (state),
      .kind        (kind),
      .page_wide   (page_wide),
      .acc_cpu     (acc_cpu),
      .vid_addr    (vid_addr),
      .cpu_addr    (cpu_addr),
      .cpu_wdata   (cpu_wdata),
      .dram_din    (dram_din),
      .col_din     (col_din),
      .dram_ma     (dram_ma),
      .dram_dout   (dram_dout),
      .col_addr    (col_addr),
      .col_dout    (col_dout),
      .fetch_word  (fetch_word),
      .fetch_valid (fetch_valid),
      .cpu_rdata   (cpu_rdata),
      .cpu_rvalid  (cpu_rvalid)
   );

endmodule

// File: rtl/vfm_memif_chk.sv
module vfm_memif_chk #(
   parameter int COL_AW = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dram_ras_n,
   input logic              dram_cas_n,
   input logic              dram_we_n,
   input logic              col_we_n,
   input logic [COL_AW-1:0] col_addr,
   input logic              fetch_valid,
   input logic              cpu_rvalid
);

   AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);                                  // R3
   AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |=> $fell(dram_cas_n));                      // R3
   AST_COLADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras_n && $past(!dram_ras_n)) |-> $stable(col_addr));    // R4
   AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |=> !fetch_valid);                                 // R5
   AST_FETCH_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (!dram_cas_n && !dram_ras_n));                 // R5
   AST_STROBES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_cas_n) |-> $rose(dram_ras_n));                      // R6
   AST_DRAM_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_we_n |-> !dram_cas_n);                                   // R10
   AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !col_we_n));                                   // R9
   AST_VALID_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_valid && cpu_rvalid));                                 // R11

endmodule

bind vfm_memif vfm_memif_chk #(.COL_AW(COL_AW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dram_ras_n  (dram_ras_n),
   .dram_cas_n  (dram_cas_n),
   .dram_we_n   (dram_we_n),
   .col_we_n    (col_we_n),
   .col_addr    (col_addr),
   .fetch_valid (fetch_valid),
   .cpu_rvalid  (cpu_rvalid)
);

// File: tb/test_vfm_memif.sv
module test_vfm_memif;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic page_wide = 1'b1;
   logic acc_start = 1'b0, acc_cpu = 1'b0, cpu_we = 1'b0, cpu_col = 1'b0;
   logic [AW-1:0] vid_addr = '0, cpu_addr = '0;
   logic [7:0] cpu_wdata = '0, cpu_rdata, dram_dout, dram_din = '0;
   logic cpu_rvalid, dram_ras_n, dram_cas_n, dram_we_n, col_we_n, fetch_valid;
   logic [7:0] dram_ma;
   logic [9:0] col_addr;
   logic [3:0] col_dout, col_din = '0;
   logic [11:0] fetch_word;

   int checks = 0, failures = 0;
   bit done = 0;

   logic [7:0] mem_dram [DEPTH];
   logic [3:0] mem_col  [1024];
   logic [7:0] ref_dram [DEPTH];
   logic [3:0] ref_col  [1024];
   logic [11:0] exp_fetch_q [$];
   logic [7:0]  exp_cpu_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   vfm_memif i_vfm_memif (
      .clk(clk), .rst_n(rst_n), .page_wide(page_wide), .acc_start(acc_start),
      .acc_cpu(acc_cpu), .vid_addr(vid_addr), .cpu_addr(cpu_addr),
      .cpu_we(cpu_we), .cpu_col(cpu_col), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .dram_ma(dram_ma),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_dout(dram_dout), .dram_din(dram_din), .col_addr(col_addr),
      .col_we_n(col_we_n), .col_dout(col_dout), .col_din(col_din),
      .fetch_word(fetch_word), .fetch_valid(fetch_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory models: row latched on RAS fall, column applied while CAS low
   logic prev_ras_n = 1'b1;
   logic [7:0] row_q = '0;
   always @(negedge clk) begin
      int unsigned ma;
      if (!dram_ras_n && prev_ras_n) row_q = dram_ma;
      prev_ras_n = dram_ras_n;
      if (!dram_cas_n) begin
         ma = page_wide ? {row_q[3:0], dram_ma} : {row_q[4:0], dram_ma[6:0]};
         if (!dram_we_n) mem_dram[ma] = dram_dout;
         dram_din = mem_dram[ma];
      end
      if (!col_we_n) mem_col[col_addr] = col_dout;
      col_din = mem_col[col_addr];
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && fetch_valid) begin
         if (exp_fetch_q.size() == 0) chk(0, "R11 unexpected fetch_valid", 1, 0);
         else begin
            logic [11:0] e;
            e = exp_fetch_q.pop_front();
            chk(fetch_word == e, "R5 fetch_word", fetch_word, e);
         end
      end
      if (rst_n && cpu_rvalid) begin
         if (exp_cpu_q.size() == 0) chk(0, "R7 unexpected cpu_rvalid", 1, 0);
         else begin
            logic [7:0] e;
            e = exp_cpu_q.pop_front();
            chk(cpu_rdata == e, "R7 R8 cpu_rdata", cpu_rdata, e);
         end
      end
   end

   // driver: called at a negedge, returns at the negedge after the access
   task automatic access(input bit cpu, input bit we, input bit col,
                         input logic [AW-1:0] a, input logic [7:0] wd, input bit hold);
      logic [7:0] erow, ecol;
      erow = page_wide ? 8'(a >> 8) : 8'(a >> 7);
      ecol = page_wide ? a[7:0] : {1'b0, a[6:0]};
      acc_start = 1'b1; acc_cpu = cpu; cpu_we = we; cpu_col = col; cpu_wdata = wd;
      vid_addr = cpu ? ~a : a;
      cpu_addr = cpu ? a : ~a;
      if (!cpu) exp_fetch_q.push_back({ref_col[a[9:0]], ref_dram[a]});
      else if (!we) exp_cpu_q.push_back(col ? {4'h0, ref_col[a[9:0]]} : ref_dram[a]);
      else if (col) ref_col[a[9:0]] = wd[3:0];
      else ref_dram[a] = wd;
      @(negedge clk);
      if (!hold) acc_start = 1'b0;
      vid_addr = '1; cpu_addr = '1; cpu_wdata = 8'h5A;
      chk(!dram_ras_n && dram_cas_n, "R2 row strobes", {dram_ras_n, dram_cas_n}, 2'b01);
      chk(dram_ma == erow, "R2 row address", dram_ma, erow);
      chk(col_addr == a[9:0], "R4 col_addr", col_addr, a[9:0]);
      @(negedge clk);
      chk(!dram_cas_n && !dram_ras_n, "R3 column strobes", {dram_ras_n, dram_cas_n}, 0);
      chk(dram_ma == ecol, "R3 column address", dram_ma, ecol);
      chk(col_addr == a[9:0], "R4 col_addr held", col_addr, a[9:0]);
      chk(dram_we_n == !(cpu && we && !col), "R10 R11 dram_we_n", dram_we_n, !(cpu && we && !col));
      chk(col_we_n == !(cpu && we && col), "R9 R11 col_we_n", col_we_n, !(cpu && we && col));
      if (cpu && we && col) chk(col_dout == wd[3:0], "R9 col_dout", col_dout, wd[3:0]);
      if (cpu && we && !col) chk(dram_dout == wd, "R10 dram_dout", dram_dout, wd);
      @(negedge clk);
      chk(!dram_ras_n && !dram_cas_n, "R5 strobes low at capture", {dram_ras_n, dram_cas_n}, 0);
      chk(fetch_valid == !cpu, "R5 R11 fetch_valid timing", fetch_valid, !cpu);
      @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && col_we_n, "R6 strobes released",
          {dram_ras_n, dram_cas_n, dram_we_n, col_we_n}, 4'hF);
      if (hold) begin
         acc_start = 1'b0;
         @(negedge clk);
         chk(dram_ras_n, "R6 held start ignored", dram_ras_n, 1);
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem_dram[i] = 8'(i * 7 + 3);
         ref_dram[i] = 8'(i * 7 + 3);
      end
      for (int i = 0; i < 1024; i++) begin
         mem_col[i] = 4'(i * 5 + 1);
         ref_col[i] = 4'(i * 5 + 1);
      end
      repeat (3) @(negedge clk);
      chk(dram_ras_n && dram_cas_n && dram_we_n && col_we_n && !fetch_valid && !cpu_rvalid,
          "R1 reset state", {dram_ras_n, dram_cas_n, dram_we_n, col_we_n}, 4'hF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dram_ras_n && !fetch_valid, "R1 idle after reset", dram_ras_n, 1);

      // R2 R3 R5: both strap settings, addresses differing at bits 7 and 8
      for (int p = 1; p >= 0; p--) begin
         page_wide = p[0];
         access(0, 0, 0, 12'h000, 0, 0);
         access(0, 0, 0, 12'hABC, 0, 0);
         access(0, 0, 0, 12'hFFF, 0, 0);
         access(0, 0, 0, 12'h17F, 0, 0);
         access(0, 0, 0, 12'h280, 0, 0);
      end

      // R7 R8 R9 R10: CPU slots
      page_wide = 1'b1;
      access(1, 0, 0, 12'h345, 0, 0);         // R7 DRAM read
      access(1, 1, 0, 12'h345, 8'hC3, 0);     // R10 DRAM write
      access(0, 0, 0, 12'h345, 0, 0);         // R10 readback by video
      access(1, 1, 1, 12'h1A5, 8'hE9, 0);     // R9 colour write
      access(0, 0, 0, 12'h1A5, 0, 0);         // R9 nibble in fetch_word[11:8]
      access(0, 0, 0, 12'h5A5, 0, 0);         // R9 same colour cell, other DRAM page
      page_wide = 1'b0;
      access(1, 1, 1, 12'h2FF, 8'h36, 0);     // R9 under narrow page
      access(1, 0, 1, 12'h2FF, 0, 0);         // R8 colour read
      access(0, 0, 0, 12'h2FF, 0, 0);
      access(1, 1, 0, 12'h080, 8'h71, 0);     // R10 narrow page write
      access(0, 0, 0, 12'h080, 0, 0);

      // R6: start held through a busy access
      access(0, 0, 0, 12'h9C3, 0, 1);

      repeat (3) @(negedge clk);
      chk(exp_fetch_q.size() == 0, "R5 missing fetches", exp_fetch_q.size(), 0);
      chk(exp_cpu_q.size() == 0, "R7 missing cpu reads", exp_cpu_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule